// File: doc/BRIEF.md
# Bit-Serial Multiplierless Second-Order IIR Section

This block is one second-order recursive filter stage that needs no multiplier. It evaluates y(n) = b0·x(n) + b1·x(n−1) + b2·x(n−2) + a1·y(n−1) + a2·y(n−2) on two's-complement fractions that arrive one bit per clock, least significant bit first. A start pulse marks bit 0 of every input word, and words follow one another with no gaps.

In each clock, the current bit of each of the five operands forms a 5-bit address. That address selects a precomputed sum of coefficients from a 32-entry table. The selected sum goes into a shift-right accumulator. At the sign bit position the sum is subtracted instead of added. After W clocks the accumulator holds the full sum of products. A serializer then takes a window of W accumulator bits and sends it out serially during the next word period. The serial output therefore feeds the next stage of a cascade directly, and it uses the same start pulse.

The coefficients are elaboration-time parameters, given as signed integers scaled by 2^COEF_FRAC. The block produces one output sample every W clocks.

Top module: `da_biquad_serial`

## Requirements
- R1: Every operand is a W-bit two's-complement fraction, sent LSB first, one bit per clock. `frm_start` is high exactly in the clock that carries bit 0 of `x_ser`, and successive words follow every W clocks without a gap.
- R2: The result y(n) of the word x(n) that enters in frame n leaves on `y_ser` during frame n+1. Bit k of y(n) is on `y_ser` in clock k of that frame, so bit 0 appears in the clock where `frm_start` is high. This is a latency of exactly one word.
- R3: y(n) is exact relative to the table. It equals the sum over k < W−1 of T[a_k]·2^k, minus T[a_(W−1)]·2^(W−1), with no loss and no overflow inside the accumulator.
- R4: The table address a_k takes x(n) bit k on bit 0, x(n−1) on bit 1, x(n−2) on bit 2, y(n−1) on bit 3 and y(n−2) on bit 4. Each entry is the sum of the selected coefficients, rounded to the nearest multiple of 2^−(R−3), with ties going upward. The entry is then saturated to an R-bit signed value. Address 0 gives 0.
- R5: The output word is accumulator bits [OUT_LSB +: W]. This floors the sum at weight 2^OUT_LSB and keeps the low W bits, so it wraps on overflow. The default OUT_LSB = R−3 gives the output the same format as the input.
- R6: x(n−1), x(n−2) and y(n−2) are the earlier words delayed by exactly W and 2W clocks. An impulse input therefore yields the fixed-point impulse response of the recurrence.
- R7: A synchronous active-high `rst` clears all history, the accumulator and the output. `y_ser` is 0 from the first clock after reset until the first result. After reset, an impulse produces the same response as at start-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | High in the clock of input bit 0 |
| x_ser | input | 1 | Serial input sample, LSB first |
| y_ser | output | 1 | Serial output sample, LSB first, aligned to `frm_start` |

## Verification
Bit k of y(n) is due in clock k of the frame after x(n), which is W+k clocks after bit 0 of x(n). Bit 0 appears in the same clock as the next start pulse. The bench drives each input bit just after a falling edge and samples `y_ser` shortly afterwards, within the same clock. It compares that sample with the bit of a reference word computed from its own model of the table and recurrence before the frame starts. Impulse, step, random and extreme-value words, plus a reset in mid-stream, cover the delays, the sign-bit subtraction and the output window.

// File: rtl/dab_pkg.sv
package dab_pkg;
  // Sum of the coefficients selected by sel, rounded to table resolution and saturated.
  function automatic longint tbl_entry(int unsigned sel, longint c0, longint c1, longint c2,
                                       longint c3, longint c4, int kf, int tf, int r);
    longint s;
    longint v;
    longint lim;
    int sh;
    s = 0;
    if (sel[0]) s += c0;
    if (sel[1]) s += c1;
    if (sel[2]) s += c2;
    if (sel[3]) s += c3;
    if (sel[4]) s += c4;
    sh = kf - tf;
    if (sh > 0) v = (s + (longint'(1) <<< (sh - 1))) >>> sh;
    else        v = s <<< (-sh);
    lim = longint'(1) <<< (r - 1);
    if (v > lim - 1) v = lim - 1;
    if (v < -lim)    v = -lim;
    return v;
  endfunction
endpackage

// File: rtl/dab_coef_rom.sv
module dab_coef_rom #(
  parameter int R         = 14,
  parameter int COEF_FRAC = 16,
  parameter int C0 = 0,
  parameter int C1 = 0,
  parameter int C2 = 0,
  parameter int C3 = 0,
  parameter int C4 = 0
) (
  input  logic [4:0]          addr,
  output logic signed [R-1:0] term
);
  import dab_pkg::*;
  localparam int TBL_FRAC = R - 3;
  localparam int ENTRIES  = 32;

  logic signed [R-1:0] rom [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    localparam longint VAL = tbl_entry(g, C0, C1, C2, C3, C4, COEF_FRAC, TBL_FRAC, R);
    assign rom[g] = VAL[R-1:0];
  end

  assign term = rom[addr];
endmodule

// File: rtl/dab_bit_delay.sv
module dab_bit_delay #(
  parameter int W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {din, sr_q[W-1:1]};
  end

  assign dout = sr_q[0];
endmodule

// File: rtl/dab_accum.sv
module dab_accum #(
  parameter int W = 12,
  parameter int R = 14,
  localparam int H  = R + 2,
  localparam int PW = H + W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                neg,
  input  logic signed [R-1:0] term,
  output logic [PW-1:0]       p
);
  logic [PW-1:0]      acc_q;
  logic signed [H-1:0] hi;
  logic signed [H:0]   base;
  logic signed [H:0]   addend;
  logic signed [H:0]   total;

  assign hi = acc_q[PW-1 -: H];

  always_comb begin
    base   = start ? '0 : {hi[H-1], hi};
    addend = {{3{term[R-1]}}, term};
    if (neg) addend = -addend;
    total  = base + addend;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= {total[H:1], total[0], acc_q[W-1:1]};
  end

  assign p = acc_q;

  // R3: the partial sum never reaches the guard bits
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (hi[H-1] == hi[H-2]) && (hi[H-2] == hi[H-3]));
endmodule

// File: rtl/dab_serializer.sv
module dab_serializer #(
  parameter int W       = 12,
  parameter int PW      = 28,
  parameter int OUT_LSB = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] p,
  output logic          ser
);
  logic [W-1:0] word;
  logic [W-1:0] sr_q;
  logic         unused_p;

  assign word     = p[OUT_LSB +: W];
  assign unused_p = ^p;
  assign ser      = load ? word[0] : sr_q[0];

  always_ff @(posedge clk) begin
    if (rst)       sr_q <= '0;
    else if (load) sr_q <= {1'b0, word[W-1:1]};
    else           sr_q <= {1'b0, sr_q[W-1:1]};
  end
endmodule

// File: rtl/da_biquad_serial.sv
module da_biquad_serial #(
  parameter int W         = 12,
  parameter int R         = 14,
  parameter int COEF_FRAC = 16,
  parameter int OUT_LSB   = R - 3,
  parameter int B0 = 19661,
  parameter int B1 = 13107,
  parameter int B2 = 6554,
  parameter int A1 = 39322,
  parameter int A2 = -19661
) (
  input  logic clk,
  input  logic rst,
  input  logic frm_start,
  input  logic x_ser,
  output logic y_ser
);
  localparam int CW = $clog2(W + 1);
  localparam int PW = R + 2 + W;

  logic [CW-1:0]       cnt_q;
  logic [CW-1:0]       pos;
  logic                sign_pos;
  logic                seen_q;
  logic                x1, x2, y2;
  logic [4:0]          addr;
  logic signed [R-1:0] term;
  logic [PW-1:0]       p;

  assign pos      = frm_start ? '0 : cnt_q;
  assign sign_pos = (pos == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= (pos == CW'(W)) ? pos : pos + 1'b1;
      seen_q <= seen_q | frm_start;
    end
  end

  dab_bit_delay #(.W(W)) u_dx1 (.clk(clk), .rst(rst), .din(x_ser), .dout(x1));
  dab_bit_delay #(.W(W)) u_dx2 (.clk(clk), .rst(rst), .din(x1),    .dout(x2));
  dab_bit_delay #(.W(W)) u_dy2 (.clk(clk), .rst(rst), .din(y_ser), .dout(y2));

  assign addr = {y2, y_ser, x2, x1, x_ser};

  dab_coef_rom #(.R(R), .COEF_FRAC(COEF_FRAC),
                 .C0(B0), .C1(B1), .C2(B2), .C3(A1), .C4(A2)) u_rom (
    .addr(addr), .term(term));

  dab_accum #(.W(W), .R(R)) u_acc (
    .clk(clk), .rst(rst), .start(frm_start), .neg(sign_pos), .term(term), .p(p));

  dab_serializer #(.W(W), .PW(PW), .OUT_LSB(OUT_LSB)) u_ser (
    .clk(clk), .rst(rst), .load(frm_start), .p(p), .ser(y_ser));

  // R1: after the first word, start pulses come exactly every W clocks
  p_frame_period_r1: assert property (@(posedge clk) disable iff (rst)
    (seen_q && frm_start) |-> (cnt_q == CW'(W)));
  p_frame_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (seen_q && cnt_q == CW'(W)) |-> frm_start);
  // R4: the all-zero address contributes nothing
  p_table_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (addr == 5'd0) |-> (term == '0));
  // R7: output is quiet right after reset
  p_quiet_after_reset_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !y_ser);
endmodule

// File: tb/tb_da_biquad_serial.sv
`timescale 1ns/1ps
module tb_da_biquad_serial;
  localparam int W = 12;
  localparam int R = 14;
  localparam int KF = 16;
  localparam int OUTL = R - 3;
  localparam int CB0 = 19661, CB1 = 13107, CB2 = 6554, CA1 = 39322, CA2 = -19661;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_start = 1'b0;
  logic x_ser = 1'b0;
  logic y_ser;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  longint tbl [32];
  int xm1 = 0, xm2 = 0, ym1 = 0, ym2 = 0;

  always #5 clk = ~clk;

  da_biquad_serial #(.W(W), .R(R), .COEF_FRAC(KF), .OUT_LSB(OUTL),
    .B0(CB0), .B1(CB1), .B2(CB2), .A1(CA1), .A2(CA2)) dut (
    .clk(clk), .rst(rst), .frm_start(frm_start), .x_ser(x_ser), .y_ser(y_ser));

  // R4: table built from real arithmetic, round half up, saturate
  function automatic longint ref_entry(int a);
    real s;
    real v;
    real lim;
    s = 0.0;
    if (a % 2 == 1)       s += CB0;
    if ((a / 2) % 2 == 1) s += CB1;
    if ((a / 4) % 2 == 1) s += CB2;
    if ((a / 8) % 2 == 1) s += CA1;
    if ((a / 16) % 2 == 1) s += CA2;
    v = $floor(s / (2.0 ** KF) * (2.0 ** (R - 3)) + 0.5);
    lim = 2.0 ** (R - 1);
    if (v > lim - 1.0) v = lim - 1.0;
    if (v < -lim) v = -lim;
    return longint'(v);
  endfunction

  function automatic int bitof(int v, int k);
    return (v >> k) & 1;
  endfunction

  // R3 R5: per-bit table sum, sign position subtracted, window then wrap
  function automatic int ref_y(int x0, int x1, int x2, int y1, int y2);
    longint acc;
    longint wide;
    int w;
    acc = 0;
    for (int k = 0; k < W; k++) begin
      int a;
      a = bitof(x0, k) + 2 * bitof(x1, k) + 4 * bitof(x2, k)
        + 8 * bitof(y1, k) + 16 * bitof(y2, k);
      if (k == W - 1) acc -= tbl[a] * (longint'(1) << k);
      else            acc += tbl[a] * (longint'(1) << k);
    end
    wide = acc >>> OUTL;
    w = int'(wide & ((longint'(1) << W) - 1));
    if (w >= (1 << (W - 1))) w -= (1 << W);
    return w;
  endfunction

  task automatic check(bit got, bit exp, string tag, int f, int k);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s frame %0d bit %0d: y_ser=%0b expected %0b", tag, f, k, got, exp);
    end
  endtask

  task automatic run_frame(int xv, string tag, int f);
    int ynew;
    ynew = ref_y(xv, xm1, xm2, ym1, ym2);
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      frm_start = (k == 0);
      x_ser = bitof(xv, k)[0];
      #2;
      check(y_ser, bitof(ym1, k)[0], tag, f, k);   // R2: y(n-1) during frame n
    end
    xm2 = xm1; xm1 = xv; ym2 = ym1; ym1 = ynew;
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1'b1; frm_start = 1'b0; x_ser = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      #2;
      check(y_ser, 1'b0, tag, -1, c);
    end
    @(negedge clk);
    rst = 1'b0;
    #2;
    check(y_ser, 1'b0, tag, -1, 99);
    xm1 = 0; xm2 = 0; ym1 = 0; ym2 = 0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 32; a++) tbl[a] = ref_entry(a);
    do_reset("R7 reset state");
    // R1 R2 R6: impulse response from start-up
    for (int f = 0; f < 30; f++) run_frame((f == 0) ? (1 << (W - 2)) : 0, "R1 R2 R6 impulse", f);
    // R3: step input, steady state
    for (int f = 0; f < 40; f++) run_frame(1 << (W - 3), "R3 step", f);
    // R3 R4 R5: random and extreme words, sign bit set and clear
    for (int f = 0; f < 150; f++) begin
      int xv;
      if (f % 37 == 5)       xv = -(1 << (W - 1));
      else if (f % 37 == 6)  xv = (1 << (W - 1)) - 1;
      else                   xv = int'($urandom % (1 << (W - 1))) - (1 << (W - 2));
      run_frame(xv, "R3 R4 R5 random", f);
    end
    // R7: reset in mid-stream, then impulse matches start-up response
    do_reset("R7 mid-stream reset");
    for (int f = 0; f < 20; f++) run_frame((f == 0) ? (1 << (W - 2)) : 0, "R7 R6 impulse after reset", f);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule